// File: doc/BRIEF.md
# Bipolar Line Violation and Carrier Monitor

This block watches the two rails of a bipolar (alternate mark inversion) T1 receive interface, one bit per line clock. It flags every mark that repeats the polarity of the previous mark. Such a bit is a bipolar violation, unless it belongs to a B8ZS substitution codeword. Violations are counted in a saturating counter that the host reads as two bytes and can clear or preset. A carrier-loss flag rises after a long run of zeros. It falls only after the ones density has held up for a long stretch. Two level flags report runs of at least 8 and at least 16 zeros, and a one-cycle pulse marks each recognised B8ZS codeword.

A codeword can only be recognised once all eight of its bits have arrived. For that reason the violation decision is taken at the end of an eight-stage delay line. The violation flag is aligned with a delayed copy of the received data (`line_data`), so it is high during the bit time of the accused bit on that stream. When a system ties both rails together to carry NRZ data, a sample with both rails high is taken as a plain one. Such a sample is never accused and leaves polarity tracking untouched, so violation checking switches itself off.

Top module: `t1_bpv_monitor`

## Requirements
- R1: The rails are sampled on the falling edge of `line_clk`. Rail changes between a falling edge and the next falling edge do not affect the sampled bit. `line_data` is the sampled mark (either rail high) delayed by nine rising edges.
- R2: `carrier_loss` rises at the rising edge that processes the 192nd consecutive zero (both rails low). A run of 191 zeros followed by a mark leaves it low.
- R3: Once set, `carrier_loss` falls only after 192 consecutive processed bits in each of which the zero run ending at that bit is shorter than 8. A run of 8 or more zeros restarts that count.
- R4: `bpv` is high, aligned with `line_data`, for a single-rail mark whose rail matches the rail of the previous single-rail mark, and low otherwise. The first mark after reset is never accused.
- R5: The pattern zero, zero, zero, V, B, zero, V, B is a B8ZS codeword. Here V has the polarity of the previous mark, B the opposite, the second V the polarity of the first B, and the last B the opposite of that. No bit of this pattern is accused. `b8zs_seen` pulses for one cycle, two rising edges after the codeword's last bit is sampled.
- R6: A sample with both rails high is a mark for carrier and zero-run purposes. It is never accused and does not change the polarity reference.
- R7: `zeros8` is high while the current zero run is at least 8, and `zeros16` while it is at least 16.
- R8: The violation counter increments on the same edge at which `bpv` rises for a violation. Its upper byte is `bpv_cnt_hi` and its lower byte `bpv_cnt_lo`.
- R9: The counter holds at 0xFFFF rather than wrapping.
- R10: `cnt_clear` zeroes the counter and `cnt_load` loads `cnt_preset`. Clear wins over load, and either one overrides an increment on the same edge.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Recovered line clock, one bit per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_pos | input | 1 | Positive-rail mark input |
| rail_neg | input | 1 | Negative-rail mark input |
| cnt_clear | input | 1 | Synchronous counter clear |
| cnt_load | input | 1 | Synchronous counter preset strobe |
| cnt_preset | input | 16 | Value loaded by `cnt_load` |
| bpv | output | 1 | Violation flag, aligned with `line_data` |
| line_data | output | 1 | Delayed received data (mark = 1) |
| b8zs_seen | output | 1 | One-cycle pulse per recognised codeword |
| zeros8 | output | 1 | Zero run of 8 or more in progress |
| zeros16 | output | 1 | Zero run of 16 or more in progress |
| carrier_loss | output | 1 | Carrier-loss flag |
| bpv_cnt_hi | output | 8 | Upper byte of the violation count |
| bpv_cnt_lo | output | 8 | Lower byte of the violation count |

## Verification
The assertions assume that the rails settle before each falling edge of the line clock. They also assume that a sample with both rails high appears only when the rails are tied for NRZ data, and that the host strobes are synchronous single-cycle pulses. The bench drives each bit just after a rising edge and scrambles the rails just after the falling edge that samples them. It places violations only directly after a mark, so that random traffic cannot form an accidental codeword. It also starts every stream with a plain mark, so that no codeword arrives before the polarity reference exists.

// File: rtl/lm_pkg.sv
package lm_pkg;

  localparam int CW_LEN   = 8;
  localparam int ZS_SHORT = 8;
  localparam int ZS_LONG  = 16;

  // Codeword mark positions (V, B, V, B) after one shift of the delay line.
  localparam logic [CW_LEN-1:0] CW_EXEMPT_NEXT = 8'b0011_0110;

  typedef struct packed {
    logic mark;   // either rail high
    logic pos;    // positive rail only
    logic both;   // rails tied: NRZ one
  } rail_sym_t;

  // Index CW_LEN-1 holds the oldest bit of the window.
  function automatic logic cw_match(input logic [CW_LEN-1:0] m,
                                    input logic [CW_LEN-1:0] p,
                                    input logic [CW_LEN-1:0] b,
                                    input logic ref_pol,
                                    input logic ref_ok);
    logic zeros_ok, marks_ok, pol_ok;
    zeros_ok = ~(m[7] | m[6] | m[5] | m[2]);
    marks_ok = m[4] & m[3] & m[1] & m[0] & ~(b[4] | b[3] | b[1] | b[0]);
    pol_ok   = (p[4] == ref_pol) & (p[3] != ref_pol) &
               (p[1] != ref_pol) & (p[0] == ref_pol);
    return ref_ok & zeros_ok & marks_ok & pol_ok;
  endfunction

endpackage

// File: rtl/lm_capture.sv
module lm_capture
  import lm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rail_p,
  input  logic      rail_n,
  output rail_sym_t smp
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp <= '0;
    end else begin
      smp.mark <= rail_p | rail_n;
      smp.pos  <= rail_p & ~rail_n;
      smp.both <= rail_p & rail_n;
    end
  end

endmodule

// File: rtl/lm_carrier.sv
module lm_carrier
  import lm_pkg::*;
#(
  parameter int LOS_SET  = 192,
  parameter int LOS_CLR  = 192,
  parameter int DENS_GAP = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  rail_sym_t smp,
  output logic      carrier_loss,
  output logic      zeros8,
  output logic      zeros16
);

  localparam int RUN_MAX = (LOS_SET > ZS_LONG) ? LOS_SET : ZS_LONG;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int GOOD_W  = $clog2(LOS_CLR + 1);

  logic [RUN_W-1:0]  zrun, zrun_n;
  logic [GOOD_W-1:0] good;
  logic              dense_bit;

  function automatic logic [RUN_W-1:0] run_step(input logic [RUN_W-1:0] r);
    return (&r) ? r : r + 1'b1;
  endfunction

  assign zrun_n    = smp.mark ? '0 : run_step(zrun);
  assign dense_bit = zrun_n < RUN_W'(DENS_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun         <= '0;
      good         <= '0;
      carrier_loss <= 1'b0;
    end else begin
      zrun <= zrun_n;
      if (!carrier_loss) begin
        good <= '0;
        if (zrun_n >= RUN_W'(LOS_SET)) carrier_loss <= 1'b1;
      end else if (dense_bit) begin
        if (good == GOOD_W'(LOS_CLR - 1)) begin
          carrier_loss <= 1'b0;
          good         <= '0;
        end else begin
          good <= good + 1'b1;
        end
      end else begin
        good <= '0;
      end
    end
  end

  assign zeros8  = zrun >= RUN_W'(ZS_SHORT);
  assign zeros16 = zrun >= RUN_W'(ZS_LONG);

  a_r2_los_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    (zrun >= RUN_W'(LOS_SET)) |-> carrier_loss);

  a_r3_clear_needs_density: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_loss) |-> (zrun < RUN_W'(DENS_GAP)));

  a_r7_long_run_nested: assert property (@(posedge clk) disable iff (!rst_n)
    zeros16 |-> zeros8);

endmodule

// File: rtl/lm_bpv_detect.sv
module lm_bpv_detect
  import lm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rail_sym_t smp,
  output logic      viol_evt,
  output logic      bpv,
  output logic      dly_data,
  output logic      b8zs_det
);

  localparam int TOP = CW_LEN - 1;

  logic [CW_LEN-1:0] sr_m, sr_p, sr_b, sr_x;
  logic              last_pol, last_ok;
  logic              cw_hit;

  assign cw_hit   = cw_match(sr_m, sr_p, sr_b, last_pol, last_ok);
  assign viol_evt = sr_m[TOP] & ~sr_b[TOP] & ~sr_x[TOP] & last_ok &
                    (sr_p[TOP] == last_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_m     <= '0;
      sr_p     <= '0;
      sr_b     <= '0;
      sr_x     <= '0;
      last_pol <= 1'b0;
      last_ok  <= 1'b0;
      bpv      <= 1'b0;
      dly_data <= 1'b0;
      b8zs_det <= 1'b0;
    end else begin
      sr_m     <= {sr_m[TOP-1:0], smp.mark};
      sr_p     <= {sr_p[TOP-1:0], smp.pos};
      sr_b     <= {sr_b[TOP-1:0], smp.both};
      sr_x     <= {sr_x[TOP-1:0], 1'b0} | (cw_hit ? CW_EXEMPT_NEXT : '0);
      bpv      <= viol_evt;
      dly_data <= sr_m[TOP];
      b8zs_det <= cw_hit;
      if (sr_m[TOP] && !sr_b[TOP]) begin
        last_pol <= sr_p[TOP];
        last_ok  <= 1'b1;
      end
    end
  end

  a_r4_flag_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
    bpv |-> dly_data);

  a_r5_codeword_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    sr_x[TOP] |=> !bpv);

  a_r6_nrz_never_accused: assert property (@(posedge clk) disable iff (!rst_n)
    sr_b[TOP] |=> !bpv);

endmodule

// File: rtl/lm_bpv_counter.sv
module lm_bpv_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] v,
                                               input logic step);
    return (step && !(&v)) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (load) count <= preset;
    else           count <= sat_add(count, inc);
  end

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && inc && !(&count)) |=> (count == CNT_W'($past(count) + 1'b1)));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && (&count)) |=> (&count));

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

endmodule

// File: rtl/t1_bpv_monitor.sv
module t1_bpv_monitor
  import lm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOS_SET  = 192,
  parameter int LOS_CLR  = 192,
  parameter int DENS_GAP = 8
) (
  input  logic               line_clk,
  input  logic               rst_n,
  input  logic               rail_pos,
  input  logic               rail_neg,
  input  logic               cnt_clear,
  input  logic               cnt_load,
  input  logic [CNT_W-1:0]   cnt_preset,
  output logic               bpv,
  output logic               line_data,
  output logic               b8zs_seen,
  output logic               zeros8,
  output logic               zeros16,
  output logic               carrier_loss,
  output logic [CNT_W/2-1:0] bpv_cnt_hi,
  output logic [CNT_W/2-1:0] bpv_cnt_lo
);

  localparam int HALF = CNT_W / 2;

  rail_sym_t        smp;
  logic             viol_evt;
  logic [CNT_W-1:0] count;

  lm_capture u_capture (
    .clk    (line_clk),
    .rst_n  (rst_n),
    .rail_p (rail_pos),
    .rail_n (rail_neg),
    .smp    (smp)
  );

  lm_carrier #(
    .LOS_SET  (LOS_SET),
    .LOS_CLR  (LOS_CLR),
    .DENS_GAP (DENS_GAP)
  ) u_carrier (
    .clk          (line_clk),
    .rst_n        (rst_n),
    .smp          (smp),
    .carrier_loss (carrier_loss),
    .zeros8       (zeros8),
    .zeros16      (zeros16)
  );

  lm_bpv_detect u_detect (
    .clk      (line_clk),
    .rst_n    (rst_n),
    .smp      (smp),
    .viol_evt (viol_evt),
    .bpv      (bpv),
    .dly_data (line_data),
    .b8zs_det (b8zs_seen)
  );

  lm_bpv_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk    (line_clk),
    .rst_n  (rst_n),
    .inc    (viol_evt),
    .clr    (cnt_clear),
    .load   (cnt_load),
    .preset (cnt_preset),
    .count  (count)
  );

  assign bpv_cnt_hi = count[CNT_W-1 -: HALF];
  assign bpv_cnt_lo = count[HALF-1:0];

  a_r8_flag_with_count: assert property (@(posedge line_clk) disable iff (!rst_n)
    ($rose(bpv) && !$past(cnt_clear) && !$past(cnt_load) && !(&$past(count)))
      |-> (count != $past(count)));

endmodule

// File: tb/t1_bpv_monitor_bench.sv
`timescale 1ns/1ps
module t1_bpv_monitor_bench;

  logic clk = 1'b0, rst_n = 1'b0, rp = 1'b0, rn = 1'b0;
  logic hclr = 1'b0, hload = 1'b0;
  logic [15:0] hval = '0;
  logic bpv, line_data, b8zs_seen, zeros8, zeros16, carrier_loss;
  logic [7:0] cnt_hi, cnt_lo;

  t1_bpv_monitor u_t1_bpv_monitor (
    .line_clk(clk), .rst_n(rst_n), .rail_pos(rp), .rail_neg(rn),
    .cnt_clear(hclr), .cnt_load(hload), .cnt_preset(hval),
    .bpv(bpv), .line_data(line_data), .b8zs_seen(b8zs_seen),
    .zeros8(zeros8), .zeros16(zeros16), .carrier_loss(carrier_loss),
    .bpv_cnt_hi(cnt_hi), .bpv_cnt_lo(cnt_lo));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, k = 0;
  bit done = 0;
  int run = 0, good = 0, mcnt = 0, host_val = 0;
  bit mlos = 0, host_pend = 0;
  bit last_p = 0, prev_mark = 0, any_mark = 0;
  bit rb[16], rd[16];
  int rk[16];
  int b8_sent = 0, b8_seen = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Called 1 ns after a rising edge: the design has processed bit k-1.
  task automatic observe();
    int idx;
    string tl;
    if (b8zs_seen) b8_seen++;
    tl = mlos ? "R3 carrier clear" : "R2 carrier set";
    if (k > 0) begin
      if (rd[(k-1) & 15]) run = 0; else if (run < 255) run++;
      if (!mlos) begin
        good = 0;
        if (run >= 192) mlos = 1;
      end else if (run < 8) begin
        good++;
        if (good == 192) begin mlos = 0; good = 0; end
      end else good = 0;
    end
    idx = (k - 9) & 15;
    if (host_pend) mcnt = host_val;
    else if (rb[idx] && mcnt != 65535) mcnt++;
    chk(tl, int'(carrier_loss), int'(mlos));
    chk("R7 zeros8", int'(zeros8), int'(run >= 8));
    chk("R7 zeros16", int'(zeros16), int'(run >= 16));
    chk(rk[idx] == 1 ? "R5 codeword bit" : rk[idx] == 2 ? "R6 nrz bit" : "R4 violation flag",
        int'(bpv), int'(rb[idx]));
    chk("R1 delayed data", int'(line_data), int'(rd[idx]));
    chk(host_pend ? "R10 host op" : (mcnt == 65535 ? "R9 saturation" : "R8 count"),
        int'({cnt_hi, cnt_lo}), mcnt);
  endtask

  task automatic send_bit(input bit p, input bit n, input bit eb, input int kind,
                          input bit hc, input bit hl, input logic [15:0] hv);
    @(posedge clk); #1;
    observe();
    #1;
    rp = p; rn = n; hclr = hc; hload = hl; hval = hv;
    host_pend = hc | hl;
    host_val = hc ? 0 : int'(hv);
    rb[k & 15] = eb; rd[k & 15] = p | n; rk[k & 15] = kind;
    prev_mark = p | n;
    @(negedge clk); #2;
    rp = 1'($urandom_range(0, 1));
    rn = 1'($urandom_range(0, 1));
    k++;
  endtask

  task automatic zero();
    send_bit(0, 0, 0, 0, 0, 0, 16'h0);
  endtask

  task automatic host(input bit hc, input bit hl, input logic [15:0] hv);
    send_bit(0, 0, 0, 0, hc, hl, hv);
  endtask

  task automatic mark(input bit viol);
    bit p;
    p = viol ? last_p : !last_p;
    send_bit(p, !p, viol, 0, 0, 0, 16'h0);
    last_p = p;
    any_mark = 1;
  endtask

  task automatic nrz(input bit m);
    send_bit(m, m, 0, m ? 2 : 0, 0, 0, 16'h0);
  endtask

  task automatic b8zs();
    bit v;
    v = last_p;
    zero(); zero(); zero();
    send_bit(v, !v, 0, 1, 0, 0, 16'h0);
    send_bit(!v, v, 0, 1, 0, 0, 16'h0);
    zero();
    send_bit(!v, v, 0, 1, 0, 0, 16'h0);
    send_bit(v, !v, 0, 1, 0, 0, 16'h0);
    b8_sent++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2182));
    for (int i = 0; i < 16; i++) begin rb[i] = 0; rd[i] = 0; rk[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset bpv", int'(bpv), 0);
    chk("R11 reset carrier", int'(carrier_loss), 0);
    chk("R11 reset flags", int'({line_data, b8zs_seen, zeros8, zeros16}), 0);
    chk("R11 reset count", int'({cnt_hi, cnt_lo}), 0);
    rst_n = 1'b1;           // this bit period carries a zero: bit 0
    k = 1;

    // Random traffic with violations, codewords, zero bursts and host ops.
    mark(0);
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40) zero();
      else if (r < 78) mark(0);
      else if (r < 86) mark(prev_mark && any_mark);
      else if (r < 92) begin if (any_mark) b8zs(); else zero(); end
      else if (r < 97) begin
        int n;
        n = $urandom_range(5, 20);
        for (int j = 0; j < n; j++) zero();
      end
      else if (r < 98) host(1, 0, 16'h0);
      else if (r < 99) host(0, 1, 16'($urandom));
      else host(1, 1, 16'($urandom));
    end

    // R2: 191 zeros do not set carrier loss, 200 do.
    mark(0);
    for (int i = 0; i < 191; i++) zero();
    mark(0);
    #1 chk("R2 no loss after 191 zeros", int'(carrier_loss), 0);
    for (int i = 0; i < 200; i++) zero();
    #1 chk("R2 loss after long run", int'(carrier_loss), 1);
    // R3: gaps of 8 zeros never clear, gaps of 7 clear.
    for (int i = 0; i < 30; i++) begin
      mark(0);
      for (int j = 0; j < 8; j++) zero();
    end
    #1 chk("R3 held by 8-zero gaps", int'(carrier_loss), 1);
    for (int i = 0; i < 30; i++) begin
      mark(0);
      for (int j = 0; j < 7; j++) zero();
    end
    #1 chk("R3 cleared by density", int'(carrier_loss), 0);

    // R6: tied rails, then polarity reference must be unchanged.
    mark(0);
    for (int i = 0; i < 400; i++) nrz(1'($urandom_range(0, 1)));
    mark(0);
    mark(1);

    // R9 and R10: saturation, clear-over-load priority.
    host(0, 1, 16'hFFF0);
    mark(0);
    for (int i = 0; i < 30; i++) mark(1);
    for (int i = 0; i < 12; i++) zero();
    #1 chk("R9 held at max", int'({cnt_hi, cnt_lo}), 65535);
    host(1, 1, 16'h1234);
    zero();
    #1 chk("R10 clear beats load", int'({cnt_hi, cnt_lo}), 0);
    host(0, 1, 16'hA55A);
    zero();
    #1 chk("R8 byte split hi", int'(cnt_hi), 8'hA5);
    chk("R8 byte split lo", int'(cnt_lo), 8'h5A);

    for (int i = 0; i < 16; i++) zero();
    chk("R5 codeword pulses", b8_seen, b8_sent);
    done = 1;
    summary();
    $finish;
  end

endmodule